// File: doc/BRIEF.md
# Host Command Byte Decoder

This block sits behind a byte-wide host link of a sensor-hub style peripheral and turns each host transaction into an action. A transaction opens with a start strobe that carries a command byte and a read/write direction. A stream of data bytes follows, in either direction, and an end strobe closes it. The top bits of the command byte choose between a register access and a memory write. The remaining bits name the register or the target bank.

Register reads capture a 16-bit value from an attached register block and return it as two bytes. Register writes collect up to two bytes and issue a single 16-bit write when the transaction ends. Memory writes pass every payload byte straight on to a bank write path. Each transaction finishes with a one-cycle done pulse and a success flag.

Two counters gate access. The first is a wake-hold count, raised and lowered by the host's keep-awake requests. The second is a pending power-on-failure count. The failure count is reduced by one each time the last wake hold is released.

Top module: `hcd_top`

## Requirements
- R1: A read transaction whose command byte has bit 7 set returns the register value selected by bits 6:0, high byte first and low byte second. Every further byte reads as zero.
- R2: A write transaction whose command byte has bit 7 set takes its first data byte as the high byte and its second as the low byte. Any bytes after the second are ignored. One 16-bit write to index bits 6:0 is issued in the same cycle as done.
- R3: A register write with exactly one data byte writes that byte as the high byte and zero as the low byte.
- R4: A register write with no data bytes completes with ok set and issues no register write.
- R5: A write transaction whose command byte has bits 7:6 equal to 00 forwards each data byte one cycle after it arrives. The bank number is bits 5:0 of the command byte, and the transaction completes with ok set.
- R6: A command byte with bits 7:6 equal to 01 is rejected. Done comes with ok clear, and no memory or register write is issued.
- R7: A read transaction whose command byte has bit 7 clear is rejected. Its returned bytes are zero and done comes with ok clear.
- R8: While the power-on-failure count is nonzero, every transaction is rejected, with no forwarded writes and zero read data.
- R9: A wake release that brings the wake-hold count from one to zero lowers a nonzero power-on-failure count by one. A failure-count load takes priority over this decrement.
- R10: A transaction started while the wake-hold count is zero raises protoErr for one cycle, on the cycle after the start, and is rejected.
- R11: done is a one-cycle pulse on the cycle after the end strobe, and ok is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txnStart | input | 1 | Transaction start strobe; cmdByte and isRead are valid with it |
| cmdByte | input | 8 | Command byte |
| isRead | input | 1 | 1 for a read transaction, 0 for a write |
| txnEnd | input | 1 | Transaction end strobe |
| rxValid | input | 1 | Write data byte valid |
| rxData | input | 8 | Write data byte |
| txRdAck | input | 1 | Host consumed the current read byte |
| txData | output | 8 | Current read byte |
| wakeAcquire | input | 1 | Raise the wake-hold count |
| wakeRelease | input | 1 | Lower the wake-hold count |
| failLoad | input | 1 | Load the power-on-failure count |
| failValue | input | 4 | Value for failLoad |
| regRdIdx | output | 7 | Register index to read, taken from cmdByte |
| regRdData | input | 16 | Register value for regRdIdx |
| regWrEn | output | 1 | Register write strobe |
| regWrIdx | output | 7 | Register write index |
| regWrData | output | 16 | Register write value |
| memWrEn | output | 1 | Memory payload byte strobe |
| memBank | output | 6 | Target bank |
| memData | output | 8 | Memory payload byte |
| done | output | 1 | Transaction complete pulse |
| ok | output | 1 | Transaction success flag, valid with done |
| protoErr | output | 1 | Access attempted without a wake hold |

## Verification
The assertions assume a well-formed host. txnStart and txnEnd never fall in the same cycle. No data byte or read acknowledge arrives in a start or end cycle. A new start comes only after the previous transaction has ended. The bench drives each transaction through tasks that open, stream and close it in separate cycles, so the random command bytes, directions and byte counts stay inside these rules. The failure and wake counters are changed only between transactions.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

  typedef enum logic [1:0] {
    MODE_REJECT = 2'd0,
    MODE_REG_RD = 2'd1,
    MODE_REG_WR = 2'd2,
    MODE_MEM_WR = 2'd3
  } modeT;

  typedef struct packed {
    logic capture;
    modeT mode;
    logic wrByte;
    logic rdAdv;
    logic finish;
  } strobeT;

endpackage

// File: rtl/hcd_ctrl.sv
module hcd_ctrl
  import hcd_pkg::*;
#(
  parameter int WAKE_W = 4,
  parameter int FAIL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic [1:0]        cmdTop,
  input  logic              isRead,
  input  logic              txnEnd,
  input  logic              rxValid,
  input  logic              txRdAck,
  input  logic              wakeAcquire,
  input  logic              wakeRelease,
  input  logic              failLoad,
  input  logic [FAIL_W-1:0] failValue,
  output strobeT            stb,
  output logic              protoErr,
  output logic [WAKE_W-1:0] wakeCnt,
  output logic [FAIL_W-1:0] failCnt
);

  localparam logic [WAKE_W-1:0] WAKE_MAX = '1;

  logic active;
  modeT mode, newMode;
  logic wakeUp, wakeDn;

  always_comb begin
    if (failCnt != '0 || wakeCnt == '0) newMode = MODE_REJECT;
    else if (cmdTop[1])                 newMode = isRead ? MODE_REG_RD : MODE_REG_WR;
    else if (isRead || cmdTop[0])       newMode = MODE_REJECT;
    else                                newMode = MODE_MEM_WR;
  end

  assign wakeUp = wakeAcquire && !wakeRelease && wakeCnt != WAKE_MAX;
  assign wakeDn = wakeRelease && !wakeAcquire && wakeCnt != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt <= '0;
      failCnt <= '0;
    end else begin
      if (wakeUp)      wakeCnt <= wakeCnt + 1'b1;
      else if (wakeDn) wakeCnt <= wakeCnt - 1'b1;
      if (failLoad)
        failCnt <= failValue;
      else if (wakeDn && wakeCnt == WAKE_W'(1) && failCnt != '0)
        failCnt <= failCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      mode     <= MODE_REJECT;
      protoErr <= 1'b0;
    end else begin
      protoErr <= txnStart && wakeCnt == '0;
      if (txnStart) begin
        active <= 1'b1;
        mode   <= newMode;
      end else if (txnEnd && active) begin
        active <= 1'b0;
        mode   <= MODE_REJECT;
      end
    end
  end

  always_comb begin
    stb.capture = txnStart;
    stb.mode    = mode;
    stb.wrByte  = rxValid && active && !txnStart;
    stb.rdAdv   = txRdAck && active && !txnStart && mode == MODE_REG_RD;
    stb.finish  = txnEnd && active && !txnStart;
  end

endmodule

// File: rtl/hcd_datapath.sv
module hcd_datapath
  import hcd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  logic [DATA_W-1:0]   cmdByte,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [REG_W-1:0]    regRdData,
  output logic [DATA_W-2:0]   regRdIdx,
  output logic [DATA_W-1:0]   txData,
  output logic                regWrEn,
  output logic [DATA_W-2:0]   regWrIdx,
  output logic [REG_W-1:0]    regWrData,
  output logic                memWrEn,
  output logic [DATA_W-3:0]   memBank,
  output logic [DATA_W-1:0]   memData,
  output logic                done,
  output logic                ok
);

  localparam int IDX_W  = DATA_W - 1;
  localparam int BANK_W = DATA_W - 2;

  logic [IDX_W-1:0]  idxQ;
  logic [REG_W-1:0]  rdShadow;
  logic [DATA_W-1:0] hiQ, loQ;
  logic [1:0]        byteCnt;
  logic              regWrByte;

  assign regRdIdx  = cmdByte[IDX_W-1:0];
  assign regWrIdx  = idxQ;
  assign memBank   = idxQ[BANK_W-1:0];
  assign regWrByte = stb.wrByte && stb.mode == MODE_REG_WR;

  always_comb begin
    txData = '0;
    if (stb.mode == MODE_REG_RD) begin
      if (byteCnt == 2'd0)      txData = rdShadow[REG_W-1 -: DATA_W];
      else if (byteCnt == 2'd1) txData = rdShadow[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ     <= '0;
      rdShadow <= '0;
      hiQ      <= '0;
      loQ      <= '0;
      byteCnt  <= '0;
    end else if (stb.capture) begin
      idxQ     <= cmdByte[IDX_W-1:0];
      rdShadow <= regRdData;
      byteCnt  <= '0;
    end else if (regWrByte || stb.rdAdv) begin
      if (regWrByte && byteCnt == 2'd0) hiQ <= rxData;
      if (regWrByte && byteCnt == 2'd1) loQ <= rxData;
      if (byteCnt != 2'd2) byteCnt <= byteCnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      memData   <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      memWrEn <= stb.wrByte && stb.mode == MODE_MEM_WR;
      if (stb.wrByte) memData <= rxData;
      done    <= stb.finish;
      regWrEn <= stb.finish && stb.mode == MODE_REG_WR && byteCnt != 2'd0;
      if (stb.finish) begin
        ok        <= stb.mode != MODE_REJECT;
        regWrData <= {hiQ, (byteCnt == 2'd2) ? loQ : {DATA_W{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/hcd_top.sv
module hcd_top
  import hcd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16,
  parameter int WAKE_W = 4,
  parameter int FAIL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic [DATA_W-1:0] cmdByte,
  input  logic              isRead,
  input  logic              txnEnd,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              txRdAck,
  output logic [DATA_W-1:0] txData,
  input  logic              wakeAcquire,
  input  logic              wakeRelease,
  input  logic              failLoad,
  input  logic [FAIL_W-1:0] failValue,
  output logic [DATA_W-2:0] regRdIdx,
  input  logic [REG_W-1:0]  regRdData,
  output logic              regWrEn,
  output logic [DATA_W-2:0] regWrIdx,
  output logic [REG_W-1:0]  regWrData,
  output logic              memWrEn,
  output logic [DATA_W-3:0] memBank,
  output logic [DATA_W-1:0] memData,
  output logic              done,
  output logic              ok,
  output logic              protoErr
);

  strobeT            stb;
  logic [WAKE_W-1:0] wakeCnt;
  logic [FAIL_W-1:0] failCnt;

  hcd_ctrl #(.WAKE_W(WAKE_W), .FAIL_W(FAIL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart),
    .cmdTop(cmdByte[DATA_W-1 -: 2]), .isRead(isRead), .txnEnd(txnEnd),
    .rxValid(rxValid), .txRdAck(txRdAck), .wakeAcquire(wakeAcquire),
    .wakeRelease(wakeRelease), .failLoad(failLoad), .failValue(failValue),
    .stb(stb), .protoErr(protoErr), .wakeCnt(wakeCnt), .failCnt(failCnt)
  );

  hcd_datapath #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdByte(cmdByte), .rxData(rxData),
    .regRdData(regRdData), .regRdIdx(regRdIdx), .txData(txData),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .memWrEn(memWrEn), .memBank(memBank), .memData(memData),
    .done(done), .ok(ok)
  );

endmodule

// File: rtl/hcd_checker.sv
module hcd_checker #(
  parameter int WAKE_W = 4,
  parameter int FAIL_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              txnStart,
  input logic              done,
  input logic              ok,
  input logic              regWrEn,
  input logic              protoErr,
  input logic              wakeAcquire,
  input logic              wakeRelease,
  input logic              failLoad,
  input logic [WAKE_W-1:0] wakeCnt,
  input logic [FAIL_W-1:0] failCnt
);

  logic rejectPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rejectPend <= 1'b0;
    else if (txnStart) rejectPend <= failCnt != '0;
    else if (done)     rejectPend <= 1'b0;
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_wr_with_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (done && ok));

  p_fail_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && rejectPend) |-> !ok);

  p_proto_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txnStart && wakeCnt == '0) |=> protoErr);

  p_fail_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeRelease && !wakeAcquire && wakeCnt == WAKE_W'(1) && failCnt != '0 && !failLoad)
      |=> failCnt == $past(failCnt) - 1'b1);

endmodule

bind hcd_top hcd_checker #(.WAKE_W(WAKE_W), .FAIL_W(FAIL_W)) u_hcd_checker (
  .clk(clk), .rstN(rstN), .txnStart(txnStart), .done(done), .ok(ok),
  .regWrEn(regWrEn), .protoErr(protoErr), .wakeAcquire(wakeAcquire),
  .wakeRelease(wakeRelease), .failLoad(failLoad), .wakeCnt(wakeCnt),
  .failCnt(failCnt)
);

// File: tb/test_hcd_top.sv
module test_hcd_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txnStart = 1'b0, isRead = 1'b0, txnEnd = 1'b0;
  logic [7:0]  cmdByte = '0, rxData = '0;
  logic        rxValid = 1'b0, txRdAck = 1'b0;
  logic        wakeAcquire = 1'b0, wakeRelease = 1'b0, failLoad = 1'b0;
  logic [3:0]  failValue = '0;
  logic [7:0]  txData, memData;
  logic [6:0]  regRdIdx, regWrIdx;
  logic [15:0] regRdData, regWrData;
  logic        regWrEn, memWrEn, done, ok, protoErr;
  logic [5:0]  memBank;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] regModel(input logic [6:0] idx);
    return {1'b1, idx, {1'b0, idx} ^ 8'h5A};
  endfunction

  assign regRdData = regModel(regRdIdx);

  hcd_top i_hcd_top (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .cmdByte(cmdByte),
    .isRead(isRead), .txnEnd(txnEnd), .rxValid(rxValid), .rxData(rxData),
    .txRdAck(txRdAck), .txData(txData), .wakeAcquire(wakeAcquire),
    .wakeRelease(wakeRelease), .failLoad(failLoad), .failValue(failValue),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .regWrEn(regWrEn),
    .regWrIdx(regWrIdx), .regWrData(regWrData), .memWrEn(memWrEn),
    .memBank(memBank), .memData(memData), .done(done), .ok(ok),
    .protoErr(protoErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 reject, 1 register read, 2 register write, 3 memory write
  function automatic int expKind(input logic [7:0] cmd, input logic rd, input logic gated);
    if (gated) return 0;
    if (cmd[7]) return rd ? 1 : 2;
    if (rd || cmd[6]) return 0;
    return 3;
  endfunction

  function automatic string tagOf(input logic [7:0] cmd, input logic rd, input int n);
    if (cmd[7] && rd) return "R1";
    if (cmd[7] && n == 0) return "R4";
    if (cmd[7] && n == 1) return "R3";
    if (cmd[7]) return "R2";
    if (rd) return "R7";
    if (cmd[6]) return "R6";
    return "R5";
  endfunction

  task automatic wakePulse(input bit acq);
    @(negedge clk);
    wakeAcquire = acq;
    wakeRelease = !acq;
    @(negedge clk);
    wakeAcquire = 1'b0;
    wakeRelease = 1'b0;
  endtask

  task automatic loadFail(input logic [3:0] v);
    @(negedge clk);
    failLoad = 1'b1;
    failValue = v;
    @(negedge clk);
    failLoad = 1'b0;
  endtask

  task automatic runTxn(input logic [7:0] cmd, input logic rd, input int n,
                        input bit gated, input string tagIn);
    int kind = expKind(cmd, rd, gated);
    string tag = (tagIn == "") ? tagOf(cmd, rd, n) : tagIn;
    logic [15:0] rv = regModel(cmd[6:0]);
    logic [7:0] hi = 8'h00;
    logic [7:0] lo = 8'h00;
    @(negedge clk);
    txnStart = 1'b1;
    cmdByte = cmd;
    isRead = rd;
    @(negedge clk);
    txnStart = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (rd) begin
        logic [7:0] eb = 8'h00;
        if (kind == 1 && i == 0) eb = rv[15:8];
        if (kind == 1 && i == 1) eb = rv[7:0];
        chk({tag, " read byte"}, 32'(txData), 32'(eb));
        txRdAck = 1'b1;
        @(negedge clk);
        txRdAck = 1'b0;
      end else begin
        logic [7:0] b = 8'($urandom);
        if (i == 0) hi = b;
        if (i == 1) lo = b;
        rxValid = 1'b1;
        rxData = b;
        @(negedge clk);
        rxValid = 1'b0;
        chk({tag, " memWrEn"}, 32'(memWrEn), 32'(kind == 3));
        if (kind == 3) begin
          chk({tag, " memData"}, 32'(memData), 32'(b));
          chk({tag, " memBank"}, 32'(memBank), 32'(cmd[5:0]));
        end
      end
    end
    txnEnd = 1'b1;
    @(negedge clk);
    txnEnd = 1'b0;
    chk({tag, " R11 done"}, 32'(done), 32'd1);
    chk({tag, " ok"}, 32'(ok), 32'(kind != 0));
    chk({tag, " regWrEn"}, 32'(regWrEn), 32'(kind == 2 && n > 0));
    if (kind == 2 && n > 0) begin
      chk({tag, " regWrData"}, 32'(regWrData), 32'({hi, (n >= 2) ? lo : 8'h00}));
      chk({tag, " regWrIdx"}, 32'(regWrIdx), 32'(cmd[6:0]));
    end
    @(negedge clk);
    chk("R11 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7021));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset done", 32'(done), 32'd0);
    chk("reset regWrEn", 32'(regWrEn), 32'd0);
    chk("reset memWrEn", 32'(memWrEn), 32'd0);
    chk("reset txData", 32'(txData), 32'd0);
    chk("reset protoErr", 32'(protoErr), 32'd0);

    // R10: no wake hold
    @(negedge clk);
    txnStart = 1'b1; cmdByte = 8'h85; isRead = 1'b1;
    @(negedge clk);
    txnStart = 1'b0;
    chk("R10 protoErr", 32'(protoErr), 32'd1);
    chk("R10 read data zero", 32'(txData), 32'd0);
    txnEnd = 1'b1;
    @(negedge clk);
    txnEnd = 1'b0;
    chk("R10 protoErr single", 32'(protoErr), 32'd0);
    chk("R10 ok", 32'(ok), 32'd0);

    wakePulse(1'b1);

    // directed corners
    runTxn(8'h93, 1'b1, 4, 1'b0, "");
    runTxn(8'hA1, 1'b0, 2, 1'b0, "");
    runTxn(8'hA2, 1'b0, 4, 1'b0, "");
    runTxn(8'hC4, 1'b0, 1, 1'b0, "");
    runTxn(8'hFF, 1'b0, 0, 1'b0, "");
    runTxn(8'h3F, 1'b0, 3, 1'b0, "");
    runTxn(8'h00, 1'b0, 1, 1'b0, "");
    runTxn(8'h55, 1'b0, 2, 1'b0, "");
    runTxn(8'h12, 1'b1, 2, 1'b0, "");

    // R8 and R9: failure count gating and wake-release decrement
    loadFail(4'd2);
    runTxn(8'h81, 1'b1, 2, 1'b1, "R8");
    runTxn(8'h07, 1'b0, 2, 1'b1, "R8");
    runTxn(8'h8A, 1'b0, 2, 1'b1, "R8");
    wakePulse(1'b0);
    wakePulse(1'b1);
    runTxn(8'h81, 1'b1, 2, 1'b1, "R9 after one release");
    wakePulse(1'b1);
    wakePulse(1'b0);
    runTxn(8'h81, 1'b1, 2, 1'b1, "R9 release not to zero");
    wakePulse(1'b0);
    wakePulse(1'b1);
    runTxn(8'h81, 1'b1, 2, 1'b0, "R9 after second release");

    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [7:0] c = 8'($urandom);
      logic r = 1'($urandom);
      int n = int'($urandom_range(0, 4));
      runTxn(c, r, n, 1'b0, "");
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule